// File: doc/BRIEF.md
# Periodic Lamp Update Controller

This block drives a bank of panel lamps from a set of writable lamp registers. Software writes lamp patterns into the registers over a small word-addressed register bus. The new values do not reach the lamps straight away. A period timer counts a 1 ms tick input, and each time the programmed period expires the block takes a snapshot of every lamp register. It offers that snapshot on a valid/ready output stream, all lamps at once.

Every expiry also sets an update event flag in the output status register, and the block can raise a level interrupt from it. The timer and the event run whether or not a panel is attached, so the block also works as a programmable interrupting timer. A two-bit test-mode field forces the snapshot to all-on or all-off. An error bit in the status register reflects a panel-absent input pin.

The output stream follows the usual rules. The snapshot is held stable while `lamp_valid` is high and `lamp_ready` is low. A beat is accepted on a cycle where both are high. If an expiry arrives while a beat is still waiting, that expiry does not replace the waiting beat; it still counts as a timer event.

Top module: `lamp_update_ctl`

## Requirements
- R1: After reset, the following values hold:
  - the status register reads 0, apart from bit 15, which follows `panel_absent`;
  - the period register reads the reset parameter (default 10);
  - every lamp register reads 0;
  - `lamp_data` is 0, and `lamp_valid` and `irq` are low.
- R2: The status register is at word address 0 and has this layout:
  - bit 15 is the panel-error flag, read-only, equal to `panel_absent`;
  - bit 7 is the update event flag, read-only;
  - bit 6 is the interrupt enable;
  - bits 1:0 are the test mode;
  - all other bits read 0, and writes to bits 15 and 7 have no effect.
- R3: The period register is at word address 1 and uses bits 9:0 of a write.
  - Bits 15:10 of a write are ignored and read back as 0.
  - A field value above 1000 is stored as 1000.
- R4: With a stored period P other than 0, the event sets on every P-th `ms_tick` pulse. Writing the period register restarts the count. With P = 0, no event is ever raised.
- R5: A status read returns the event flag and clears it. An expiry in the same cycle as the read wins: the read returns the old value and the flag stays set.
- R6: `irq` is high exactly while the event flag and the interrupt enable are both set. This holds whatever the state of `panel_absent`.
- R7: Lamp registers sit at word addresses LAMP_BASE to LAMP_BASE+NUM_LAMP-1 (default 8 to 11) and read back the last value written. A write does not change `lamp_data` before the next expiry.
- R8: On an expiry with the output slot free, `lamp_valid` rises one cycle later and `lamp_data` carries the snapshot, with lamp register i in bits 16*i+15 to 16*i. The test mode selects what the snapshot holds:
  - mode 0: the register contents;
  - mode 1 (lamp test) or mode 2 (full test): all ones;
  - mode 3 (powerless): all zeros.
- R9: Back-pressure on the output stream works as follows:
  - while `lamp_valid` is high and `lamp_ready` is low, `lamp_data` holds and `lamp_valid` stays high;
  - an expiry in that state leaves the waiting beat unchanged, but the event flag is still set;
  - an accepted beat with no new expiry drops `lamp_valid`.
- R10: A read is answered on `bus_rdata` with `bus_rvalid` one cycle after the request. Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| panel_absent | input | 1 | High when no panel is connected |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 16 | Read data |
| irq | output | 1 | Update interrupt, level |
| lamp_valid | output | 1 | Snapshot beat valid |
| lamp_ready | input | 1 | Lamp sink accepts beat |
| lamp_data | output | 16*NUM_LAMP | Lamp snapshot |

## Verification
The assertions assume the following about the block's inputs:
- `ms_tick` is a single-cycle pulse;
- register requests last one cycle each;
- nothing toggles while reset is asserted.

The stimulus meets these assumptions:
- inputs are driven only on falling edges;
- each tick and each bus request is held for exactly one cycle;
- reset is released before the first tick.

The stream holding property leaves `lamp_ready` unconstrained, and the bench drives it low across expiries on purpose.

// File: rtl/lamp_ctl_pkg.sv
package lamp_ctl_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_LAMP   = 2'd1,
    TM_FULL   = 2'd2,
    TM_DARK   = 2'd3
  } test_mode_e;

  localparam int STAT_ERR_BIT = 15;
  localparam int STAT_EVT_BIT = 7;
  localparam int STAT_IE_BIT  = 6;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_PERIOD = 1;
endpackage

// File: rtl/lamp_period_timer.sv
module lamp_period_timer #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ms_tick,
  input  logic [PERIOD_W-1:0] period,
  input  logic                restart,
  output logic                expire
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W:0]   next_cnt;
  logic                enabled;

  assign enabled  = (period != '0);
  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  assign expire   = ms_tick && enabled && !restart && (next_cnt >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !enabled) begin
      cnt_q <= '0;
    end else if (ms_tick) begin
      if (expire) cnt_q <= '0;
      else        cnt_q <= next_cnt[PERIOD_W-1:0];
    end
  end

  // R4: the count stays below a nonzero period
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (cnt_q < period));
endmodule

// File: rtl/lamp_reg_bank.sv
module lamp_reg_bank #(
  parameter int NUM_LAMP  = 4,
  parameter int ADDR_W    = 5,
  parameter int LAMP_BASE = 8,
  localparam int DW       = lamp_ctl_pkg::DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_hit,
  output logic [NUM_LAMP*DW-1:0] regs_flat
);
  logic [DW-1:0] regs_q [NUM_LAMP];

  for (genvar g = 0; g < NUM_LAMP; g++) begin : g_lamp
    logic sel;
    assign sel = (addr == ADDR_W'(LAMP_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[g] <= '0;
      else if (wr && sel) regs_q[g] <= wdata;
    end

    assign regs_flat[g*DW +: DW] = regs_q[g];
  end

  always_comb begin
    rd_data = '0;
    rd_hit  = 1'b0;
    for (int i = 0; i < NUM_LAMP; i++) begin
      if (addr == ADDR_W'(LAMP_BASE + i)) begin
        rd_data = regs_q[i];
        rd_hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lamp_out_stage.sv
module lamp_out_stage #(
  parameter int NUM_LAMP = 4,
  localparam int DW      = lamp_ctl_pkg::DW,
  localparam int LW      = NUM_LAMP * DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     expire,
  input  lamp_ctl_pkg::test_mode_e mode,
  input  logic [LW-1:0]            regs_flat,
  output logic                     lamp_valid,
  input  logic                     lamp_ready,
  output logic [LW-1:0]            lamp_data
);
  import lamp_ctl_pkg::*;

  logic [LW-1:0] shaped;
  logic          slot_free;
  logic          load;

  always_comb begin
    unique case (mode)
      TM_LAMP, TM_FULL: shaped = '1;
      TM_DARK:          shaped = '0;
      default:          shaped = regs_flat;
    endcase
  end

  assign slot_free = !lamp_valid || lamp_ready;
  assign load      = expire && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamp_valid <= 1'b0;
      lamp_data  <= '0;
    end else if (load) begin
      lamp_valid <= 1'b1;
      lamp_data  <= shaped;
    end else if (lamp_valid && lamp_ready) begin
      lamp_valid <= 1'b0;
    end
  end

  // R9: a waiting beat is held unchanged
  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_valid && !lamp_ready) |=> (lamp_valid && $stable(lamp_data)));

  // R8: an expiry with a free slot presents a beat
  assert_load_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && slot_free) |=> lamp_valid);
endmodule

// File: rtl/lamp_update_ctl.sv
module lamp_update_ctl #(
  parameter int NUM_LAMP   = 4,
  parameter int ADDR_W     = 5,
  parameter int LAMP_BASE  = 8,
  parameter int PERIOD_W   = 10,
  parameter int PERIOD_MAX = 1000,
  parameter int PERIOD_RST = 10,
  localparam int DW        = lamp_ctl_pkg::DW,
  localparam int LW        = NUM_LAMP * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              panel_absent,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_rvalid,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              lamp_valid,
  input  logic              lamp_ready,
  output logic [LW-1:0]     lamp_data
);
  import lamp_ctl_pkg::*;

  logic                wr, rd;
  logic                sel_status, sel_period;
  logic                evt_q, ie_q;
  test_mode_e          mode_q;
  logic [PERIOD_W-1:0] per_q;
  logic [PERIOD_W-1:0] per_field;
  logic                expire;
  logic [DW-1:0]       bank_rd;
  logic                bank_hit;
  logic [LW-1:0]       regs_flat;
  logic [DW-1:0]       status_word;
  logic [DW-1:0]       rd_mux;

  assign wr         = bus_req && bus_we;
  assign rd         = bus_req && !bus_we;
  assign sel_status = (bus_addr == ADDR_W'(ADDR_STATUS));
  assign sel_period = (bus_addr == ADDR_W'(ADDR_PERIOD));

  assign per_field = (bus_wdata[PERIOD_W-1:0] > PERIOD_W'(PERIOD_MAX))
                   ? PERIOD_W'(PERIOD_MAX) : bus_wdata[PERIOD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= PERIOD_W'(PERIOD_RST);
      ie_q   <= 1'b0;
      mode_q <= TM_NORMAL;
      evt_q  <= 1'b0;
    end else begin
      if (wr && sel_period) per_q <= per_field;
      if (wr && sel_status) begin
        ie_q   <= bus_wdata[STAT_IE_BIT];
        mode_q <= test_mode_e'(bus_wdata[1:0]);
      end
      if (expire)                 evt_q <= 1'b1;
      else if (rd && sel_status)  evt_q <= 1'b0;
    end
  end

  lamp_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .period  (per_q),
    .restart (wr && sel_period),
    .expire  (expire)
  );

  lamp_reg_bank #(.NUM_LAMP(NUM_LAMP), .ADDR_W(ADDR_W), .LAMP_BASE(LAMP_BASE)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rd_data   (bank_rd),
    .rd_hit    (bank_hit),
    .regs_flat (regs_flat)
  );

  lamp_out_stage #(.NUM_LAMP(NUM_LAMP)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .mode       (mode_q),
    .regs_flat  (regs_flat),
    .lamp_valid (lamp_valid),
    .lamp_ready (lamp_ready),
    .lamp_data  (lamp_data)
  );

  always_comb begin
    status_word               = '0;
    status_word[STAT_ERR_BIT] = panel_absent;
    status_word[STAT_EVT_BIT] = evt_q;
    status_word[STAT_IE_BIT]  = ie_q;
    status_word[1:0]          = mode_q;
  end

  always_comb begin
    if (sel_status)      rd_mux = status_word;
    else if (sel_period) rd_mux = DW'(per_q);
    else if (bank_hit)   rd_mux = bank_rd;
    else                 rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
    end
  end

  assign irq = evt_q && ie_q;

  // R3: stored period never exceeds the maximum
  assert_period_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= PERIOD_W'(PERIOD_MAX));

  // R4: the event only rises from a timer expiry
  assert_event_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(expire));

  // R4: a zero period raises no event
  assert_no_event_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0 && !evt_q && !(wr && sel_period)) |=> !evt_q);

  // R5: a status read without expiry clears the event
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel_status && !expire) |=> !evt_q);

  // R10: read data answers one cycle after the request
  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
endmodule

// File: tb/lamp_update_ctl_test.sv
module lamp_update_ctl_test;
  localparam int N    = 4;
  localparam int BASE = 8;
  localparam int LW   = N * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ms_tick = 1'b0;
  logic          panel_absent = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [15:0]   bus_rdata;
  logic          irq;
  logic          lamp_valid;
  logic          lamp_ready = 1'b1;
  logic [LW-1:0] lamp_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lamp_update_ctl uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .panel_absent(panel_absent),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq),
    .lamp_valid(lamp_valid), .lamp_ready(lamp_ready), .lamp_data(lamp_data)
  );

  // fields: [31:16] period, [15:12] mode, [11:8] irq enable, [7:0] seed
  localparam logic [31:0] VEC [6] = '{
    32'h0001_01A5, 32'h0003_003C, 32'h0002_1100,
    32'h0004_2077, 32'h0002_31FF, 32'h0005_0112
  };

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  function automatic logic [15:0] lamp_val(input logic [7:0] seed, input int i);
    return {seed ^ 8'(i * 37), ~seed};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0]   d;
    logic [LW-1:0] exp_data, d1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(lamp_data == '0 && !lamp_valid && !irq, "R1 outputs", {lamp_valid, irq}, 0);
    bus_read(0, d);
    check(d == 16'h0000, "R1 status", d, 16'h0000);
    bus_read(1, d);
    check(d == 16'd10, "R1 period", d, 10);
    bus_read(5'(BASE + 2), d);
    check(d == 16'h0000, "R1 lamp reg", d, 0);

    // table walk: R4 R5 R6 R8
    foreach (VEC[v]) begin
      int          per  = int'(VEC[v][31:16]);
      logic [1:0]  mode = VEC[v][13:12];
      logic        ie   = VEC[v][8];
      logic [7:0]  seed = VEC[v][7:0];
      for (int i = 0; i < N; i++) bus_write(5'(BASE + i), lamp_val(seed, i));
      bus_write(0, {9'b0, ie, 4'b0, mode});
      bus_read(0, d);  // clears any stale event
      bus_write(1, 16'(per));
      for (int t = 0; t < per - 1; t++) tick();
      if (per > 1) begin
        bus_read(0, d);
        check(d[7] == 1'b0, "R4 early event", d, {9'b0, ie, 4'b0, mode});
      end
      tick();
      for (int i = 0; i < N; i++)
        exp_data[i*16 +: 16] = (mode == 2'd0) ? lamp_val(seed, i)
                             : (mode == 2'd3) ? 16'h0000 : 16'hFFFF;
      check(lamp_valid, "R8 valid", lamp_valid, 1);
      check(lamp_data == exp_data, "R8 data", lamp_data, exp_data);
      check(irq == ie, "R6 irq", irq, ie);
      bus_read(0, d);
      check(d == {8'b0, 1'b1, ie, 4'b0, mode}, "R5 event read", d,
            {8'b0, 1'b1, ie, 4'b0, mode});
      bus_read(0, d);
      check(d[7] == 1'b0 && !irq, "R5 cleared", d, 0);
    end

    // R3: saturation and ignored upper bits
    bus_write(1, 16'd1001);
    bus_read(1, d);
    check(d == 16'd1000, "R3 saturate", d, 1000);
    bus_write(1, 16'hFFFF);
    bus_read(1, d);
    check(d == 16'd1000, "R3 all ones", d, 1000);
    bus_write(1, 16'h0405);
    bus_read(1, d);
    check(d == 16'd5, "R3 upper ignored", d, 5);

    // R2: read-only bits ignore writes
    bus_write(0, 16'hFFFF);
    bus_read(0, d);
    check(d == 16'h0043, "R2 layout", d, 16'h0043);
    bus_write(0, 16'h0040);

    // R4: period write restarts the count
    bus_write(1, 16'd3);
    tick(); tick();
    bus_write(1, 16'd3);
    tick(); tick();
    bus_read(0, d);
    check(d[7] == 1'b0, "R4 restart", d, 16'h0040);
    tick();
    bus_read(0, d);
    check(d[7] == 1'b1, "R4 after restart", d, 16'h00C0);

    // R4: zero period never fires
    bus_write(1, 16'd0);
    repeat (5) tick();
    bus_read(0, d);
    check(d[7] == 1'b0 && !irq, "R4 period zero", d, 16'h0040);

    // R6: timer works with panel absent
    panel_absent = 1'b1;
    bus_write(1, 16'd1);
    tick();
    check(irq, "R6 irq no panel", irq, 1);
    bus_read(0, d);
    check(d == 16'h80C0, "R6 status no panel", d, 16'h80C0);
    panel_absent = 1'b0;

    // R5: expiry coinciding with read keeps the flag
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 0; ms_tick = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; ms_tick = 1'b0;
    check(bus_rdata[7] == 1'b0, "R5 same-cycle read", bus_rdata, 16'h0040);
    bus_read(0, d);
    check(d[7] == 1'b1, "R5 set wins", d, 16'h00C0);

    // R9: back-pressure
    lamp_ready = 1'b0;
    for (int i = 0; i < N; i++) bus_write(5'(BASE + i), 16'h1000 + 16'(i));
    for (int i = 0; i < N; i++) d1[i*16 +: 16] = 16'h1000 + 16'(i);
    tick();
    check(lamp_valid && lamp_data == d1, "R9 first beat", lamp_data, d1);
    bus_read(0, d);
    for (int i = 0; i < N; i++) bus_write(5'(BASE + i), 16'h2000 + 16'(i));
    tick();
    check(lamp_valid && lamp_data == d1, "R9 held beat", lamp_data, d1);
    bus_read(0, d);
    check(d[7] == 1'b1, "R9 event while held", d, 16'h00C0);
    @(negedge clk);
    lamp_ready = 1'b1;
    @(negedge clk);
    lamp_ready = 1'b0;
    check(!lamp_valid, "R9 accept drops valid", lamp_valid, 0);

    // R7: readback and no early effect
    bus_read(5'(BASE + 1), d);
    check(d == 16'h2001, "R7 readback", d, 16'h2001);
    check(lamp_data == d1, "R7 no early effect", lamp_data, d1);
    lamp_ready = 1'b1;

    // R10: unmapped addresses
    bus_write(5'd2, 16'hBEEF);
    bus_write(5'd31, 16'hBEEF);
    bus_read(5'd2, d);
    check(d == 16'h0000 && bus_rvalid, "R10 unmapped read", d, 0);
    bus_read(5'(BASE + N), d);
    check(d == 16'h0000, "R10 past bank", d, 0);
    bus_read(5'(BASE), d);
    check(d == 16'h2000, "R10 bank untouched", d, 16'h2000);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule